// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block is a clocked controller that sits between an internal request port and the pins of an asynchronous static RAM. A client offers one word at a time through a valid/ready handshake, with a direction flag, an address and write data. The controller then runs the pin sequence the memory needs. It drives the address and the two active-low strobes, and it controls a data-out enable for the shared data bus. On a read it captures the word from the bus and returns it to the client with a single-cycle valid pulse.

Every timing interval is a parameter counted in system clock cycles. These are the write setup before the strobe, the strobe width, the hold after the strobe, the read access time and the bus turnaround after a read. The pad ring turns the separate bus-out, bus-in and drive-enable signals into a tri-state pin. The controller drives the bus only while a write is in progress. It also keeps the write strobe and the read strobe from being low at the same time.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and right after it is released, mem_we_n and mem_oe_n are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1.
- R2: req_ready is 1 exactly when no access is in progress. A request is taken in a cycle where req_valid and req_ready are both 1, and req_ready is 0 from the next cycle until the access and any turnaround have ended.
- R3: An accepted write (req_write=1) runs three phases in the cycles right after acceptance. First come T_SETUP cycles with mem_dq_oe=1 and mem_we_n=1. Next come T_PULSE cycles with mem_we_n=0. Last come T_HOLD cycles with mem_dq_oe=1 and mem_we_n=1. mem_oe_n stays 1 throughout.
- R4: In every cycle of a write, mem_addr equals the accepted req_addr and mem_dq_out equals the accepted req_wdata.
- R5: An accepted read (req_write=0) holds mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for T_ACCESS cycles, starting in the cycle after acceptance, with mem_addr equal to the accepted req_addr.
- R6: The controller samples the read word from mem_dq_in at the clock edge that ends the last access cycle. It presents that word on rsp_rdata with rsp_valid=1 for exactly one cycle, which is the first cycle after mem_oe_n returns to 1.
- R7: mem_we_n and mem_oe_n are never 0 in the same cycle.
- R8: After a read, mem_oe_n=1 and mem_dq_oe=0 hold for T_TURN cycles before the controller becomes ready again. mem_dq_oe therefore never rises within T_TURN cycles of mem_oe_n rising.
- R9: mem_dq_oe is 0 in every cycle in which mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | DATA_W | Word returned by a read |
| mem_addr | output | ADDR_W | Address pins of the RAM |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output-enable strobe, active low |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus tri-state |
| mem_dq_in | input | DATA_W | Value seen on the data bus |

## Verification
Two cases are hard to reach from the ports. The first is a read that completes at the exact edge where the bus first carries good data. The second is a write that starts right after a read's turnaround. The bench's memory model puts junk on mem_dq_in until mem_oe_n has been low for T_ACCESS cycles, so a controller that samples one cycle early returns a wrong word. The stimulus keeps a request pending while the controller is busy, so that a write follows a read with no idle time from the client. This places the drive enable as close to the read as the turnaround allows. Reads target a small address range that earlier writes have covered, so that each returned word shows whether the matching write put the right data at the right address.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WSETUP,
      PH_WPULSE,
      PH_WHOLD,
      PH_RACCESS,
      PH_TURN
   } phase_t;

   function automatic int max_of5(input int a, input int b, input int c,
                                  input int d, input int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int T_SETUP  = 2,
   parameter int T_PULSE  = 3,
   parameter int T_HOLD   = 1,
   parameter int T_ACCESS = 3,
   parameter int T_TURN   = 2,
   parameter int CNT_W    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic ready,
   output logic accept,
   output logic capture,
   output logic we_n,
   output logic oe_n,
   output logic dq_oe
);
   localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(T_SETUP - 1);
   localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(T_PULSE - 1);
   localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(T_HOLD - 1);
   localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(T_ACCESS - 1);
   localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(T_TURN - 1);

   phase_t           phase_q, phase_d;
   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;

   sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (phase_q)
         PH_IDLE: if (req_valid) begin
            tmr_load = 1'b1;
            if (req_write) begin
               phase_d = PH_WSETUP;
               tmr_val = LD_SETUP;
            end else begin
               phase_d = PH_RACCESS;
               tmr_val = LD_ACCESS;
            end
         end
         PH_WSETUP: if (tmr_done) begin
            phase_d  = PH_WPULSE;
            tmr_load = 1'b1;
            tmr_val  = LD_PULSE;
         end
         PH_WPULSE: if (tmr_done) begin
            phase_d  = PH_WHOLD;
            tmr_load = 1'b1;
            tmr_val  = LD_HOLD;
         end
         PH_WHOLD: if (tmr_done) phase_d = PH_IDLE;
         PH_RACCESS: if (tmr_done) begin
            phase_d  = PH_TURN;
            tmr_load = 1'b1;
            tmr_val  = LD_TURN;
         end
         PH_TURN: if (tmr_done) phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign ready   = (phase_q == PH_IDLE);
   assign accept  = ready && req_valid;
   assign capture = (phase_q == PH_RACCESS) && tmr_done;
   assign we_n    = (phase_q != PH_WPULSE);
   assign oe_n    = (phase_q != PH_RACCESS);
   assign dq_oe   = (phase_q == PH_WSETUP) || (phase_q == PH_WPULSE) ||
                    (phase_q == PH_WHOLD);
endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
module sram_ctl_datapath #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_in;
      end
   end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int T_SETUP  = 2,
   parameter int T_PULSE  = 3,
   parameter int T_HOLD   = 1,
   parameter int T_ACCESS = 3,
   parameter int T_TURN   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int MAX_T = max_of5(T_SETUP, T_PULSE, T_HOLD, T_ACCESS, T_TURN);
   localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);

   if (ADDR_W < 1)   begin : g_bad_addr   $error("ADDR_W must be at least 1");   end
   if (DATA_W < 1)   begin : g_bad_data   $error("DATA_W must be at least 1");   end
   if (T_SETUP < 1)  begin : g_bad_setup  $error("T_SETUP must be at least 1");  end
   if (T_PULSE < 1)  begin : g_bad_pulse  $error("T_PULSE must be at least 1");  end
   if (T_HOLD < 1)   begin : g_bad_hold   $error("T_HOLD must be at least 1");   end
   if (T_ACCESS < 1) begin : g_bad_access $error("T_ACCESS must be at least 1"); end
   if (T_TURN < 1)   begin : g_bad_turn   $error("T_TURN must be at least 1");   end

   logic accept, capture;

   sram_ctl_fsm #(
      .T_SETUP (T_SETUP), .T_PULSE (T_PULSE), .T_HOLD (T_HOLD),
      .T_ACCESS(T_ACCESS), .T_TURN (T_TURN), .CNT_W (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .ready     (req_ready),
      .accept    (accept),
      .capture   (capture),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int T_TURN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   logic [15:0] since_oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         since_oe_q <= 16'hFFFF;
      else if (!mem_oe_n)
         since_oe_q <= '0;
      else if (since_oe_q != 16'hFFFF)
         since_oe_q <= since_oe_q + 1'b1;
   end

   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   assert_no_drive_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   assert_we_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_wr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rsp_after_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (mem_oe_n && $past(!mem_oe_n)));

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (since_oe_q >= 16'(T_TURN)));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_TURN(T_TURN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int TS = 2;
   localparam int TP = 3;
   localparam int TH = 1;
   localparam int TA = 3;
   localparam int TT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] mem_dq_in = '0;
   logic          req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out;
   logic [AW-1:0] mem_addr;

   always #2 clk = ~clk;

   sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_PULSE(TP),
              .T_HOLD(TH), .T_ACCESS(TA), .T_TURN(TT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   typedef struct {
      bit            we_n;
      bit            oe_n;
      bit            dq_oe;
      bit            wr;
      bit            rsp;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } exp_t;

   exp_t          expq[$];
   logic [DW-1:0] ram    [0:(1<<AW)-1];
   logic [DW-1:0] shadow [0:(1<<AW)-1];
   int            vectors = 0;
   int            errors  = 0;
   bit            finished = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic push_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_t e;
      e.wr = wr; e.addr = a; e.rsp = 1'b0;
      if (wr) begin
         e.data = d; e.oe_n = 1'b1; e.dq_oe = 1'b1;
         e.we_n = 1'b1; for (int i = 0; i < TS; i++) expq.push_back(e);
         e.we_n = 1'b0; for (int i = 0; i < TP; i++) expq.push_back(e);
         e.we_n = 1'b1; for (int i = 0; i < TH; i++) expq.push_back(e);
         shadow[a] = d;
      end else begin
         e.data = shadow[a]; e.we_n = 1'b1; e.dq_oe = 1'b0;
         e.oe_n = 1'b0; for (int i = 0; i < TA; i++) expq.push_back(e);
         e.oe_n = 1'b1;
         for (int i = 0; i < TT; i++) begin
            e.rsp = (i == 0);
            expq.push_back(e);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      bit            consumed;
      bit            prev_we;
      int            oe_cnt;
      int            nops;
      logic [AW-1:0] wa;
      logic [DW-1:0] wd;
      consumed = 1'b0; prev_we = 1'b1; oe_cnt = 0; nops = 0; wa = '0; wd = '0;
      for (int i = 0; i < (1 << AW); i++) begin
         ram[i]    = DW'(i * 37 + 5);
         shadow[i] = DW'(i * 37 + 5);
      end

      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1", "we_n in reset", 32'(mem_we_n), 32'd1);
      chk("R1", "oe_n in reset", 32'(mem_oe_n), 32'd1);
      chk("R1", "dq_oe in reset", 32'(mem_dq_oe), 32'd0);
      chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", 32'(req_ready), 32'd1);
      chk("R1", "we_n after reset", 32'(mem_we_n), 32'd1);
      chk("R1", "oe_n after reset", 32'(mem_oe_n), 32'd1);

      for (int cyc = 0; cyc < 4000; cyc++) begin
         bit idle_obs;
         if (cyc != 0) @(negedge clk);
         idle_obs = (expq.size() == 0);
         chk("R7", "strobe overlap", 32'(mem_we_n | mem_oe_n), 32'd1);
         if (idle_obs) begin
            chk("R2", "ready when idle", 32'(req_ready), 32'd1);
            chk("R2", "we_n idle", 32'(mem_we_n), 32'd1);
            chk("R2", "oe_n idle", 32'(mem_oe_n), 32'd1);
            chk("R8", "dq_oe idle", 32'(mem_dq_oe), 32'd0);
            chk("R6", "rsp_valid idle", 32'(rsp_valid), 32'd0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk("R2", "ready busy", 32'(req_ready), 32'd0);
            if (e.wr) begin
               chk("R3", "we_n write", 32'(mem_we_n), 32'(e.we_n));
               chk("R3", "oe_n write", 32'(mem_oe_n), 32'd1);
               chk("R3", "dq_oe write", 32'(mem_dq_oe), 32'd1);
               chk("R4", "addr write", 32'(mem_addr), 32'(e.addr));
               chk("R4", "data write", 32'(mem_dq_out), 32'(e.data));
               chk("R6", "rsp_valid write", 32'(rsp_valid), 32'd0);
            end else begin
               chk("R5", "we_n read", 32'(mem_we_n), 32'd1);
               chk("R5", "oe_n read", 32'(mem_oe_n), 32'(e.oe_n));
               if (!e.oe_n) begin
                  chk("R9", "dq_oe read", 32'(mem_dq_oe), 32'd0);
                  chk("R5", "addr read", 32'(mem_addr), 32'(e.addr));
               end else begin
                  chk("R8", "dq_oe turnaround", 32'(mem_dq_oe), 32'd0);
               end
               chk("R6", "rsp_valid read", 32'(rsp_valid), 32'(e.rsp));
               if (e.rsp) chk("R6", "rsp_rdata", 32'(rsp_rdata), 32'(e.data));
            end
         end

         // memory model: commit write on strobe rise, junk before access time
         if (!mem_we_n) begin wa = mem_addr; wd = mem_dq_out; end
         if (!prev_we && mem_we_n) ram[wa] = wd;
         prev_we = mem_we_n;
         if (!mem_oe_n) oe_cnt++; else oe_cnt = 0;
         mem_dq_in = (oe_cnt >= TA) ? ram[mem_addr] : (ram[mem_addr] ^ 16'h5A3C);

         // stimulus for the next edge; a busy controller leaves it pending
         if (cyc < 3800 && (consumed || !req_valid)) begin
            consumed = 1'b0;
            case (nops)
               0: begin req_write = 1'b1; req_addr = 8'h00; req_wdata = 16'hFFFF; end
               1: begin req_write = 1'b1; req_addr = 8'hFF; req_wdata = 16'h0000; end
               2: begin req_write = 1'b0; req_addr = 8'hFF; end
               3: begin req_write = 1'b0; req_addr = 8'h00; end
               4: begin req_write = 1'b1; req_addr = 8'h55; req_wdata = 16'h1234; end
               5: begin req_write = 1'b0; req_addr = 8'h55; end
               6: begin req_write = 1'b1; req_addr = 8'hAA; req_wdata = 16'hBEEF; end
               default: begin
                  req_write = $urandom_range(0, 1) == 1;
                  req_addr  = AW'($urandom_range(0, 15));
                  req_wdata = DW'($urandom);
               end
            endcase
            req_valid = (nops < 7) || ($urandom_range(0, 3) != 0);
            if (req_valid) nops++;
         end else if (cyc >= 3800 && (consumed || !req_valid)) begin
            req_valid = 1'b0;
            consumed  = 1'b0;
         end
         if (idle_obs && req_valid) begin
            push_op(req_write, req_addr, req_wdata);
            consumed = 1'b1;
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule